// File: doc/BRIEF.md
# Coalesced Translation Response Distributor

This block sits on the return side of a translation-request merger. Upstream ports send translation requests, and a merger folds requests for the same virtual page into one group. The merger records each group in a small outstanding-page table held here and sends a single translation request downstream. When the translated result comes back, this block finds the matching group. It then hands one response to every member of that group, one member per cycle in group order, each routed to the upstream port the member came from.

The downstream result carries a physical address, a page size given as a power of two, an uncacheable flag and a hit level. The first member's physical address is the returned address as it stands. Every later member gets the physical page frame, which is the returned address with the bits below the page size cleared, combined with that member's own in-page offset. Because the page size travels with each result, large pages are composed correctly. The table entry stays visible to the issue side's page query until the edge on which the group's last response is taken, and it is freed on that edge.

Top module: `xlat_resp_distributor`

## Requirements
- R1: After reset no response port is valid, rspReady and allocReady are 1, qryHit is 0 and rspErr is 0.
- R2: The first response of a group (outFirst=1) carries rspPaddr unchanged as its physical address.
- R3: Every later member's outPaddr equals (rspPaddr with bits below 2^rspSizeLog2 cleared) OR (the member's virtual address bits below 2^rspSizeLog2), for any page size in rspSizeLog2.
- R4: Every member of a group carries outUncache equal to the rspUncache of the group's result.
- R5: Every member of a group carries outHitLevel equal to the rspHitLevel of the group's result.
- R6: Members are presented one per cycle in the order they were allocated (member index 0 first). outValid is one-hot, with bit p set for a member whose return port is p. The first member appears in the cycle after the result is accepted.
- R7: outPopCount is 1 for a member whose prefetch flag was 0 at allocation, and 0 for a prefetch member.
- R8: While outReady for the presented member's port is 0, outValid and outPaddr hold their values and the sequence does not advance.
- R9: rspReady is 0 while a group is being distributed, and 1 in the cycle after the last member is taken.
- R10: qryHit for a group's page is 1 from allocation through the cycle in which its last member is taken. It is 0 from the next cycle on, and the slot becomes free again.
- R11: A result whose rspPage matches no valid entry is accepted and dropped: no output becomes valid, and rspErr is 1 for exactly the one cycle after acceptance.
- R12: allocReady is 0 while every table slot holds a group. An allocation stores a group whose page key is the first member's virtual address above the base page shift (12 bits by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Install a group into a free slot |
| allocReady | output | 1 | At least one slot is free |
| allocCount | input | CNT_W | Number of members in the group (1..MAX_MEMBERS) |
| allocVaddr | input | MAX_MEMBERS*VA_W | Member virtual addresses, member m at bits m*VA_W |
| allocPort | input | MAX_MEMBERS*PORT_W | Member return ports, member m at bits m*PORT_W |
| allocPrefetch | input | MAX_MEMBERS | Member prefetch flags, bit m for member m |
| qryPage | input | KEY_W | Page key looked up by the issue side |
| qryHit | output | 1 | qryPage has an outstanding group |
| rspValid | input | 1 | Downstream translation result present |
| rspReady | output | 1 | Result accepted on this cycle's edge |
| rspPage | input | KEY_W | Page key of the translated group |
| rspPaddr | input | PA_W | Translated physical address of the first member |
| rspSizeLog2 | input | SIZE_W | log2 of the translated page size |
| rspUncache | input | 1 | Translation is uncacheable |
| rspHitLevel | input | HIT_W | Level where the translation hit |
| outValid | output | NUM_PORTS | One-hot: response presented to port p |
| outReady | input | NUM_PORTS | Per-port acceptance |
| outPaddr | output | PA_W | Member physical address |
| outUncache | output | 1 | Member uncacheable flag |
| outHitLevel | output | HIT_W | Member hit level |
| outPopCount | output | 1 | Pop this level's request count (non-prefetch member) |
| outFirst | output | 1 | Response is the group's first member |
| rspErr | output | 1 | One-cycle pulse: unmatched result dropped |

## Verification
Member addresses are checked with a 4 KB page and with a 2 MB page. In the 2 MB group one member lies in a different 4 KB frame of the same large page. A design that masks with a fixed base page size would put the returned address's bits 20:12 into that member instead of its own. A stall on a later member checks that the output holds and that the group's page stays visible to the query until the last response is taken. An early retire would show qryHit falling during the stall, and a late one would show it still high after. An unmatched result checks that rspErr pulses for a single cycle with nothing presented. Filling every slot checks that allocReady drops and comes back when one group retires.

// File: rtl/xlat_dist_pkg.sv
package xlat_dist_pkg;
  typedef enum logic {
    DIST_IDLE,
    DIST_SEND
  } dist_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchRsp;  // capture result and matching slot
    logic retire;    // free the slot being distributed
  } dist_strobe_t;
endpackage

// File: rtl/xlat_dist_dp.sv
module xlat_dist_dp
  import xlat_dist_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int MAX_MEMBERS = 4,
  parameter int NUM_PORTS   = 4,
  parameter int VA_W        = 32,
  parameter int PA_W        = 32,
  parameter int BASE_SHIFT  = 12,
  parameter int SIZE_W      = 5,
  parameter int HIT_W       = 2,
  localparam int PORT_W = $clog2(NUM_PORTS),
  localparam int CNT_W  = $clog2(MAX_MEMBERS + 1),
  localparam int IDX_W  = $clog2(MAX_MEMBERS),
  localparam int EIDX_W = $clog2(NUM_ENTRIES),
  localparam int KEY_W  = VA_W - BASE_SHIFT
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dist_strobe_t                  strobe,
  input  logic                          allocValid,
  output logic                          allocReady,
  input  logic [CNT_W-1:0]              allocCount,
  input  logic [MAX_MEMBERS*VA_W-1:0]   allocVaddr,
  input  logic [MAX_MEMBERS*PORT_W-1:0] allocPort,
  input  logic [MAX_MEMBERS-1:0]        allocPrefetch,
  input  logic [KEY_W-1:0]              qryPage,
  output logic                          qryHit,
  input  logic [KEY_W-1:0]              rspPage,
  input  logic [PA_W-1:0]               rspPaddr,
  input  logic [SIZE_W-1:0]             rspSizeLog2,
  input  logic                          rspUncache,
  input  logic [HIT_W-1:0]              rspHitLevel,
  output logic                          rspHit,
  input  logic [CNT_W-1:0]              memIdx,
  output logic [CNT_W-1:0]              curCount,
  output logic [PORT_W-1:0]             curPort,
  output logic [PA_W-1:0]               outPaddr,
  output logic                          outUncache,
  output logic [HIT_W-1:0]              outHitLevel,
  output logic                          outPopCount,
  output logic                          outFirst
);
  logic [NUM_ENTRIES-1:0] entValid;
  logic [KEY_W-1:0]       entKey   [NUM_ENTRIES];
  logic [CNT_W-1:0]       entCount [NUM_ENTRIES];
  logic [VA_W-1:0]        entVa    [NUM_ENTRIES][MAX_MEMBERS];
  logic [PORT_W-1:0]      entPort  [NUM_ENTRIES][MAX_MEMBERS];
  logic [MAX_MEMBERS-1:0] entPref  [NUM_ENTRIES];

  logic [NUM_ENTRIES-1:0] rspMatch, qryMatch;
  logic [EIDX_W-1:0]      freeIdx, hitIdx, selEnt;
  logic                   freeAny;

  logic [PA_W-1:0]   rPaddr;
  logic [SIZE_W-1:0] rSize;
  logic              rUnc;
  logic [HIT_W-1:0]  rHit;

  genvar e;
  generate
    for (e = 0; e < NUM_ENTRIES; e++) begin : g_cmp
      assign rspMatch[e] = entValid[e] && (entKey[e] == rspPage);
      assign qryMatch[e] = entValid[e] && (entKey[e] == qryPage);
    end
  endgenerate

  always_comb begin
    freeIdx = '0;
    freeAny = 1'b0;
    hitIdx  = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (!entValid[i]) begin
        freeIdx = EIDX_W'(i);
        freeAny = 1'b1;
      end
      if (rspMatch[i]) hitIdx = EIDX_W'(i);
    end
  end

  assign allocReady = freeAny;
  assign qryHit     = |qryMatch;
  assign rspHit     = |rspMatch;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entValid <= '0;
    end else begin
      if (strobe.retire) entValid[selEnt] <= 1'b0;
      if (allocValid && freeAny) entValid[freeIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (allocValid && freeAny) begin
      entKey[freeIdx]   <= allocVaddr[VA_W-1:BASE_SHIFT];
      entCount[freeIdx] <= allocCount;
      entPref[freeIdx]  <= allocPrefetch;
      for (int m = 0; m < MAX_MEMBERS; m++) begin
        entVa[freeIdx][m]   <= allocVaddr[m*VA_W +: VA_W];
        entPort[freeIdx][m] <= allocPort[m*PORT_W +: PORT_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selEnt <= '0;
      rPaddr <= '0;
      rSize  <= '0;
      rUnc   <= 1'b0;
      rHit   <= '0;
    end else if (strobe.latchRsp) begin
      selEnt <= hitIdx;
      rPaddr <= rspPaddr;
      rSize  <= rspSizeLog2;
      rUnc   <= rspUncache;
      rHit   <= rspHitLevel;
    end
  end

  logic [IDX_W-1:0] mIdx;
  logic [PA_W-1:0]  pageMask, memOffset;

  assign mIdx      = memIdx[IDX_W-1:0];
  assign pageMask  = (PA_W'(1) << rSize) - PA_W'(1);
  assign memOffset = PA_W'(entVa[selEnt][mIdx]) & pageMask;

  assign curCount    = entCount[selEnt];
  assign curPort     = entPort[selEnt][mIdx];
  assign outFirst    = (memIdx == '0);
  assign outPaddr    = outFirst ? rPaddr : ((rPaddr & ~pageMask) | memOffset);
  assign outUncache  = rUnc;
  assign outHitLevel = rHit;
  assign outPopCount = ~entPref[selEnt][mIdx];
endmodule

// File: rtl/xlat_dist_ctrl.sv
module xlat_dist_ctrl
  import xlat_dist_pkg::*;
#(
  parameter int MAX_MEMBERS = 4,
  parameter int NUM_PORTS   = 4,
  localparam int PORT_W = $clog2(NUM_PORTS),
  localparam int CNT_W  = $clog2(MAX_MEMBERS + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rspValid,
  output logic                 rspReady,
  input  logic                 rspHit,
  input  logic [CNT_W-1:0]     curCount,
  input  logic [PORT_W-1:0]    curPort,
  input  logic [NUM_PORTS-1:0] outReady,
  output logic [NUM_PORTS-1:0] outValid,
  output logic [CNT_W-1:0]     memIdx,
  output dist_strobe_t         strobe,
  output logic                 rspErr
);
  dist_state_t state;
  logic        sending, fire, lastMem, dropRsp;

  assign sending  = (state == DIST_SEND);
  assign rspReady = !sending;
  assign fire     = sending && outReady[curPort];
  assign lastMem  = (memIdx + CNT_W'(1)) >= curCount;
  assign dropRsp  = !sending && rspValid && !rspHit;
  assign outValid = sending ? (NUM_PORTS'(1) << curPort) : '0;

  assign strobe.latchRsp = !sending && rspValid && rspHit;
  assign strobe.retire   = fire && lastMem;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= DIST_IDLE;
      memIdx <= '0;
      rspErr <= 1'b0;
    end else begin
      rspErr <= dropRsp;
      if (strobe.latchRsp) begin
        state  <= DIST_SEND;
        memIdx <= '0;
      end else if (fire) begin
        if (lastMem) state <= DIST_IDLE;
        else memIdx <= memIdx + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/xlat_resp_distributor.sv
module xlat_resp_distributor
  import xlat_dist_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int MAX_MEMBERS = 4,
  parameter int NUM_PORTS   = 4,
  parameter int VA_W        = 32,
  parameter int PA_W        = 32,
  parameter int BASE_SHIFT  = 12,
  parameter int SIZE_W      = 5,
  parameter int HIT_W       = 2,
  localparam int PORT_W = $clog2(NUM_PORTS),
  localparam int CNT_W  = $clog2(MAX_MEMBERS + 1),
  localparam int KEY_W  = VA_W - BASE_SHIFT
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          allocValid,
  output logic                          allocReady,
  input  logic [CNT_W-1:0]              allocCount,
  input  logic [MAX_MEMBERS*VA_W-1:0]   allocVaddr,
  input  logic [MAX_MEMBERS*PORT_W-1:0] allocPort,
  input  logic [MAX_MEMBERS-1:0]        allocPrefetch,
  input  logic [KEY_W-1:0]              qryPage,
  output logic                          qryHit,
  input  logic                          rspValid,
  output logic                          rspReady,
  input  logic [KEY_W-1:0]              rspPage,
  input  logic [PA_W-1:0]               rspPaddr,
  input  logic [SIZE_W-1:0]             rspSizeLog2,
  input  logic                          rspUncache,
  input  logic [HIT_W-1:0]              rspHitLevel,
  output logic [NUM_PORTS-1:0]          outValid,
  input  logic [NUM_PORTS-1:0]          outReady,
  output logic [PA_W-1:0]               outPaddr,
  output logic                          outUncache,
  output logic [HIT_W-1:0]              outHitLevel,
  output logic                          outPopCount,
  output logic                          outFirst,
  output logic                          rspErr
);
  dist_strobe_t      strobe;
  logic              rspHit;
  logic [CNT_W-1:0]  memIdx, curCount;
  logic [PORT_W-1:0] curPort;

  xlat_dist_ctrl #(
    .MAX_MEMBERS(MAX_MEMBERS),
    .NUM_PORTS  (NUM_PORTS)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .rspValid(rspValid),
    .rspReady(rspReady),
    .rspHit  (rspHit),
    .curCount(curCount),
    .curPort (curPort),
    .outReady(outReady),
    .outValid(outValid),
    .memIdx  (memIdx),
    .strobe  (strobe),
    .rspErr  (rspErr)
  );

  xlat_dist_dp #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .MAX_MEMBERS(MAX_MEMBERS),
    .NUM_PORTS  (NUM_PORTS),
    .VA_W       (VA_W),
    .PA_W       (PA_W),
    .BASE_SHIFT (BASE_SHIFT),
    .SIZE_W     (SIZE_W),
    .HIT_W      (HIT_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .allocValid   (allocValid),
    .allocReady   (allocReady),
    .allocCount   (allocCount),
    .allocVaddr   (allocVaddr),
    .allocPort    (allocPort),
    .allocPrefetch(allocPrefetch),
    .qryPage      (qryPage),
    .qryHit       (qryHit),
    .rspPage      (rspPage),
    .rspPaddr     (rspPaddr),
    .rspSizeLog2  (rspSizeLog2),
    .rspUncache   (rspUncache),
    .rspHitLevel  (rspHitLevel),
    .rspHit       (rspHit),
    .memIdx       (memIdx),
    .curCount     (curCount),
    .curPort      (curPort),
    .outPaddr     (outPaddr),
    .outUncache   (outUncache),
    .outHitLevel  (outHitLevel),
    .outPopCount  (outPopCount),
    .outFirst     (outFirst)
  );
endmodule

// File: rtl/xlat_dist_chk.sv
module xlat_dist_chk #(
  parameter int NUM_PORTS = 4,
  parameter int PA_W      = 32,
  parameter int HIT_W     = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_PORTS-1:0] outValid,
  input logic [NUM_PORTS-1:0] outReady,
  input logic [PA_W-1:0]      outPaddr,
  input logic                 outFirst,
  input logic [HIT_W-1:0]     outHitLevel,
  input logic                 rspValid,
  input logic                 rspReady,
  input logic [PA_W-1:0]      rspPaddr,
  input logic [HIT_W-1:0]     rspHitLevel,
  input logic                 rspErr
);
  // R6
  one_hot_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(outValid));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(outValid & ~outReady)) |=> ($stable(outValid) && $stable(outPaddr)));

  // R9
  busy_no_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|outValid) |-> !rspReady);

  // R2
  first_paddr_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rspValid && rspReady) && (|outValid)) |-> (outFirst && outPaddr == $past(rspPaddr)));

  // R5
  first_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rspValid && rspReady) && (|outValid)) |-> (outHitLevel == $past(rspHitLevel)));

  // R11
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> (outValid == '0));
endmodule

bind xlat_resp_distributor xlat_dist_chk #(
  .NUM_PORTS(NUM_PORTS),
  .PA_W     (PA_W),
  .HIT_W    (HIT_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .outValid   (outValid),
  .outReady   (outReady),
  .outPaddr   (outPaddr),
  .outFirst   (outFirst),
  .outHitLevel(outHitLevel),
  .rspValid   (rspValid),
  .rspReady   (rspReady),
  .rspPaddr   (rspPaddr),
  .rspHitLevel(rspHitLevel),
  .rspErr     (rspErr)
);

// File: tb/test_xlat_resp_distributor.sv
`timescale 1ns/1ps
module test_xlat_resp_distributor;
  localparam int NE = 4, MM = 4, NP = 4, VA_W = 32, PA_W = 32, BS = 12;
  localparam int SIZE_W = 5, HIT_W = 2, PORT_W = 2, CNT_W = 3, KEY_W = VA_W - BS;

  logic clk = 1'b0, rstN = 1'b0;
  always #4 clk = ~clk;

  logic                   allocValid = 0, allocReady;
  logic [CNT_W-1:0]       allocCount = '0;
  logic [MM*VA_W-1:0]     allocVaddr = '0;
  logic [MM*PORT_W-1:0]   allocPort = '0;
  logic [MM-1:0]          allocPrefetch = '0;
  logic [KEY_W-1:0]       qryPage = '0;
  logic                   qryHit;
  logic                   rspValid = 0, rspReady;
  logic [KEY_W-1:0]       rspPage = '0;
  logic [PA_W-1:0]        rspPaddr = '0;
  logic [SIZE_W-1:0]      rspSizeLog2 = '0;
  logic                   rspUncache = 0;
  logic [HIT_W-1:0]       rspHitLevel = '0;
  logic [NP-1:0]          outValid, outReady = '1;
  logic [PA_W-1:0]        outPaddr;
  logic                   outUncache, outPopCount, outFirst, rspErr;
  logic [HIT_W-1:0]       outHitLevel;

  xlat_resp_distributor i_xlat_resp_distributor (.*);

  int nChk = 0, nFail = 0;
  logic [VA_W-1:0]   gVa   [MM];
  logic [PORT_W-1:0] gPort [MM];
  logic              gPref [MM];
  int                gCnt;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [PA_W-1:0] compose(input logic [PA_W-1:0] rp, input int sz, input logic [VA_W-1:0] va);
    logic [PA_W-1:0] m;
    m = (PA_W'(1) << sz) - 1;
    return (rp & ~m) | (va & m);
  endfunction

  task automatic doAlloc();
    @(negedge clk);
    allocValid = 1;
    allocCount = CNT_W'(gCnt);
    for (int m = 0; m < MM; m++) begin
      allocVaddr[m*VA_W +: VA_W] = gVa[m];
      allocPort[m*PORT_W +: PORT_W] = gPort[m];
      allocPrefetch[m] = gPref[m];
    end
    @(posedge clk);
    @(negedge clk);
    allocValid = 0;
    #1;
  endtask

  task automatic sendRsp(input logic [KEY_W-1:0] pg, input logic [PA_W-1:0] pa, input int sz,
                         input bit unc, input logic [HIT_W-1:0] hl);
    @(negedge clk);
    rspValid = 1; rspPage = pg; rspPaddr = pa; rspSizeLog2 = SIZE_W'(sz);
    rspUncache = unc; rspHitLevel = hl;
    #1;
    chk(rspReady == 1, "R9 rspReady before result", rspReady, 1);
    @(posedge clk);
    @(negedge clk);
    rspValid = 0;
    #1;
  endtask

  // called at negedge+1 after acceptance, outReady all ones
  task automatic expectMembers(input logic [PA_W-1:0] pa, input int sz, input bit unc, input logic [HIT_W-1:0] hl);
    qryPage = gVa[0][VA_W-1:BS];
    for (int k = 0; k < gCnt; k++) begin
      logic [PA_W-1:0] ep;
      ep = (k == 0) ? pa : compose(pa, sz, gVa[k]);
      #0;
      chk(outValid == (NP'(1) << gPort[k]), "R6 port one-hot/order", outValid, NP'(1) << gPort[k]);
      chk(outPaddr == ep, (k == 0) ? "R2 first paddr" : "R3 member paddr", outPaddr, ep);
      chk(outFirst == (k == 0), "R2 first flag", outFirst, k == 0);
      chk(outUncache == unc, "R4 uncacheable", outUncache, unc);
      chk(outHitLevel == hl, "R5 hit level", outHitLevel, hl);
      chk(outPopCount == !gPref[k], "R7 pop count", outPopCount, !gPref[k]);
      chk(rspReady == 0, "R9 busy", rspReady, 0);
      chk(qryHit == 1, "R10 page visible", qryHit, 1);
      @(negedge clk); #1;
    end
    chk(outValid == 0, "R6 done", outValid, 0);
    chk(qryHit == 0, "R10 retired", qryHit, 0);
    chk(rspReady == 1, "R9 ready again", rspReady, 1);
  endtask

  task automatic testReset();
    #1;
    chk(outValid == 0, "R1 outValid", outValid, 0);
    chk(rspReady == 1, "R1 rspReady", rspReady, 1);
    chk(allocReady == 1, "R1 allocReady", allocReady, 1);
    chk(qryHit == 0, "R1 qryHit", qryHit, 0);
    chk(rspErr == 0, "R1 rspErr", rspErr, 0);
  endtask

  task automatic testSmallPage();
    gCnt = 3;
    gVa[0] = 32'h1234_5010; gVa[1] = 32'h1234_5abc; gVa[2] = 32'h1234_5ffc; gVa[3] = 0;
    gPort[0] = 1; gPort[1] = 3; gPort[2] = 0; gPort[3] = 0;
    gPref[0] = 0; gPref[1] = 1; gPref[2] = 0; gPref[3] = 0;
    doAlloc();
    qryPage = 20'h12345; #1;
    chk(qryHit == 1, "R12 allocated page key", qryHit, 1);
    sendRsp(20'h12345, 32'h8000_7010, 12, 0, 2);
    expectMembers(32'h8000_7010, 12, 0, 2);
  endtask

  task automatic testLargePage();
    gCnt = 4;
    gVa[0] = 32'h40a3_c008; gVa[1] = 32'h40a3_c123; gVa[2] = 32'h40a5_d777; gVa[3] = 32'h40bf_fff0;
    gPort[0] = 2; gPort[1] = 0; gPort[2] = 3; gPort[3] = 1;
    gPref[0] = 1; gPref[1] = 0; gPref[2] = 0; gPref[3] = 1;
    doAlloc();
    sendRsp(20'h40a3c, 32'h9fe3_c008, 21, 1, 1);
    expectMembers(32'h9fe3_c008, 21, 1, 1);
  endtask

  task automatic testStall();
    gCnt = 2;
    gVa[0] = 32'h0007_7100; gVa[1] = 32'h0007_7200;
    gPort[0] = 1; gPort[1] = 2;
    gPref[0] = 0; gPref[1] = 0;
    doAlloc();
    qryPage = 20'h00077;
    outReady = 4'b1011;
    sendRsp(20'h00077, 32'h0055_5100, 12, 0, 3);
    chk(outValid == 4'b0010, "R6 stall first", outValid, 4'b0010);
    @(negedge clk); #1;
    for (int c = 0; c < 3; c++) begin
      chk(outValid == 4'b0100, "R8 held valid", outValid, 4'b0100);
      chk(outPaddr == 32'h0055_5200, "R8 held paddr", outPaddr, 32'h0055_5200);
      chk(qryHit == 1, "R10 visible during stall", qryHit, 1);
      chk(rspReady == 0, "R9 busy during stall", rspReady, 0);
      @(negedge clk); #1;
    end
    outReady = '1;
    #1;
    chk(qryHit == 1, "R10 visible in last handoff cycle", qryHit, 1);
    @(negedge clk); #1;
    chk(outValid == 0, "R8 released", outValid, 0);
    chk(qryHit == 0, "R10 retired after stall", qryHit, 0);
  endtask

  task automatic testUnmatched();
    sendRsp(20'hdead0, 32'h1111_1000, 12, 0, 0);
    chk(rspErr == 1, "R11 error pulse", rspErr, 1);
    chk(outValid == 0, "R11 dropped", outValid, 0);
    @(negedge clk); #1;
    chk(rspErr == 0, "R11 single cycle", rspErr, 0);
    chk(outValid == 0, "R11 still nothing", outValid, 0);
  endtask

  task automatic testFull();
    for (int g = 0; g < NE; g++) begin
      gCnt = 1;
      gVa[0] = 32'h0a00_0000 + (g << 12) + 32'h44;
      gPort[0] = PORT_W'(g); gPref[0] = 0;
      doAlloc();
    end
    chk(allocReady == 0, "R12 table full", allocReady, 0);
    for (int g = 0; g < NE; g++) begin
      gCnt = 1;
      gVa[0] = 32'h0a00_0000 + (g << 12) + 32'h44;
      gPort[0] = PORT_W'(g); gPref[0] = 0;
      sendRsp(gVa[0][VA_W-1:BS], 32'h7700_0044 + (g << 12), 12, 0, 0);
      expectMembers(32'h7700_0044 + (g << 12), 12, 0, 0);
      chk(allocReady == 1, "R12 slot freed", allocReady, 1);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  endtask

  initial begin
    #2000000;
    nChk++; nFail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    testReset();
    testSmallPage();
    testLargePage();
    testStall();
    testUnmatched();
    testFull();
    finishRun();
  end
endmodule